// File: doc/BRIEF.md
# Tightly-coupled SRAM bank allocator

The block owns five identical 16 KB SRAM banks and gives each of them, at any moment, to exactly one of three requesters. These are an instruction tightly-coupled port, a data tightly-coupled port and a system-bus port. Two size codes pick how much memory the two tightly-coupled ports receive. Whatever those ports do not claim is gathered into one contiguous system-bus window, even when the leftover banks are not neighbours physically.

Each port issues single-cycle reads and writes. The block decodes the port address to a physical bank and a word inside it, and steers the request to that bank. It returns the read word one clock later, or zero with an error flag when the address falls outside what the port currently owns. The size codes are taken in only on a clock where no port is active, so an access never straddles a change of allocation. Because the banks themselves are never cleared, data written under one allocation stays readable under another.

Each bank is modelled as a small synchronous RAM of `2^BANK_AW` words. The slot decoding keeps the full 16 KB stride.

Top module: `tcmalloc_top`

## Requirements
- R1: While reset is asserted and after it, until a new size is taken in, the allocation is 0 KB for both tightly-coupled ports: `bus_mask` = 5'b11111, `bus_slots` = 5, and all read data and error outputs are 0.
- R2: Size code 0 means 0 KB, 1 means 16 KB, 2 means 32 KB, and 3 is treated as 0 KB. This holds for both `itcm_sz` and `dtcm_sz`.
- R3: The instruction port takes bank 1 at 16 KB, and bank 0 (offset 0x0000) plus bank 1 (offset 0x4000) at 32 KB. The data port takes bank 3 at 16 KB, and bank 2 (offset 0x0000) plus bank 3 (offset 0x4000) at 32 KB.
- R4: The bus window starts at 0x0030_0000 with 16 KB slots. Slot n sits at 0x0030_0000 + n*0x4000, and the slots hold the unclaimed banks from the highest-numbered bank downward. `bus_mask` bit b is 1 when bank b is on the bus. `bus_slots` gives the number of populated slots, which equals the count of ones in `bus_mask`.
- R5: A read returns its word on `*_rdata` in the clock after the request. In any cycle not preceded by an in-range read on that port, `*_rdata` is 0.
- R6: An access outside the port's populated range raises `*_err` for one cycle in the clock after the request, with `*_rdata` 0. The range is a tightly-coupled offset at or beyond its size, or a bus address below the window or past its populated slots. An out-of-range write changes no bank.
- R7: The size codes are taken in only at a clock edge where `i_en`, `d_en` and `b_en` are all 0, and they take effect from the next cycle. While any port is active, the old allocation stays in force.
- R8: Within a bank, the word index is address bits [2+BANK_AW-1:2] (bits [5:2] by default). The other address bits inside a 16 KB slot are ignored, so those addresses alias.
- R9: The three ports may access three different banks in the same cycle, and each access completes independently.
- R10: Bank contents survive a change of allocation, so a word written through one port is read back through whichever port owns that bank afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| itcm_sz | input | 2 | Instruction tightly-coupled size code |
| dtcm_sz | input | 2 | Data tightly-coupled size code |
| i_en | input | 1 | Instruction port access request |
| i_we | input | 1 | Instruction port write (1) or read (0) |
| i_addr | input | 15 | Instruction port byte offset |
| i_wdata | input | 32 | Instruction port write data |
| i_rdata | output | 32 | Instruction port read data |
| i_err | output | 1 | Instruction port out-of-range flag |
| d_en | input | 1 | Data port access request |
| d_we | input | 1 | Data port write (1) or read (0) |
| d_addr | input | 15 | Data port byte offset |
| d_wdata | input | 32 | Data port write data |
| d_rdata | output | 32 | Data port read data |
| d_err | output | 1 | Data port out-of-range flag |
| b_en | input | 1 | System-bus access request |
| b_we | input | 1 | System-bus write (1) or read (0) |
| b_addr | input | 32 | System-bus byte address |
| b_wdata | input | 32 | System-bus write data |
| b_rdata | output | 32 | System-bus read data |
| b_err | output | 1 | System-bus out-of-range flag |
| bus_mask | output | 5 | Banks currently visible on the bus |
| bus_slots | output | 3 | Number of populated bus slots |

## Verification
Two functions can fall in the same cycle: a new allocation being presented, and a port access that still relies on the old one. The bench changes the size codes on the very clock on which a bus read begins, and holds that read request for two cycles. It then checks that the read returns the word from the bank of the old allocation and that `bus_mask` does not move. The new mask must appear one cycle after the ports go idle. A second kind of overlap places all three ports on distinct banks in one cycle, and each result is judged against values written earlier through a known bank.

// File: rtl/tcmalloc_pkg.sv
package tcmalloc_pkg;
  localparam int NBANK    = 5;
  localparam int BW       = 3;
  localparam int NPORT    = 3;
  localparam int ITCM_TOP = 2;
  localparam int DTCM_TOP = 4;

  typedef enum logic [1:0] {OWN_ITCM = 2'd0, OWN_DTCM = 2'd1, OWN_BUS = 2'd2} owner_e;

  // number of 16 KB slots a size code grants; code 3 is unsupported
  function automatic logic [1:0] size_slots(input logic [1:0] code);
    return (code == 2'd3) ? 2'd0 : code;
  endfunction

  // which requester owns physical bank b under a given allocation
  function automatic owner_e bank_owner(input int b, input int ni, input int nd);
    if (b < ITCM_TOP && b >= ITCM_TOP - ni) return OWN_ITCM;
    if (b >= ITCM_TOP && b < DTCM_TOP && b >= DTCM_TOP - nd) return OWN_DTCM;
    return OWN_BUS;
  endfunction

  // physical bank placed in bus slot s: free banks taken from the top down
  function automatic logic [BW-1:0] bus_bank(input int s, input int ni, input int nd);
    int cnt;
    logic [BW-1:0] r;
    cnt = 0;
    r = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bank_owner(b, ni, nd) == OWN_BUS) begin
        if (cnt == s) r = BW'(b);
        cnt++;
      end
    end
    return r;
  endfunction

  // physical bank behind a tightly-coupled slot
  function automatic logic [BW-1:0] tcm_bank(input int top, input int n, input int slot);
    return BW'(top - n + slot);
  endfunction
endpackage

// File: rtl/tcmalloc_cfg.sv
module tcmalloc_cfg
  import tcmalloc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [1:0]                itcm_code,
  input  logic [1:0]                dtcm_code,
  output logic [1:0]                ni_q,
  output logic [1:0]                nd_q,
  output logic [NBANK-1:0]          bus_mask,
  output logic [BW-1:0]             bus_slots,
  output logic [NBANK-1:0][BW-1:0]  slot_bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ni_q <= 2'd0;
      nd_q <= 2'd0;
    end else if (load) begin
      ni_q <= size_slots(itcm_code);
      nd_q <= size_slots(dtcm_code);
    end
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      bus_mask[b] = (bank_owner(b, int'(ni_q), int'(nd_q)) == OWN_BUS);
    bus_slots = BW'(NBANK - int'(ni_q) - int'(nd_q));
    for (int s = 0; s < NBANK; s++)
      slot_bank[s] = bus_bank(s, int'(ni_q), int'(nd_q));
  end
endmodule

// File: rtl/tcmalloc_bank.sv
module tcmalloc_bank #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/tcmalloc_ret.sv
module tcmalloc_ret #(
  parameter int DW = 32,
  parameter int BW = 3,
  parameter int NB = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  we,
  input  logic                  hit,
  input  logic [BW-1:0]         bank,
  input  logic [NB-1:0][DW-1:0] bank_rdata,
  output logic [DW-1:0]         rdata,
  output logic                  err
);
  logic          rd_q;
  logic          err_q;
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      rd_q   <= en && hit && !we;
      err_q  <= en && !hit;
      bank_q <= bank;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++)
      if (rd_q && bank_q == BW'(b)) rdata = bank_rdata[b];
  end

  assign err = err_q;
endmodule

// File: rtl/tcmalloc_top.sv
module tcmalloc_top
  import tcmalloc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          SLOT_LOG2 = 14,
  parameter int          BANK_AW   = 4,
  parameter logic [31:0] BUS_BASE  = 32'h0030_0000,
  localparam int         TCM_AW    = SLOT_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        itcm_sz,
  input  logic [1:0]        dtcm_sz,
  input  logic              i_en,
  input  logic              i_we,
  input  logic [TCM_AW-1:0] i_addr,
  input  logic [DATA_W-1:0] i_wdata,
  output logic [DATA_W-1:0] i_rdata,
  output logic              i_err,
  input  logic              d_en,
  input  logic              d_we,
  input  logic [TCM_AW-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] d_rdata,
  output logic              d_err,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_err,
  output logic [NBANK-1:0]  bus_mask,
  output logic [BW-1:0]     bus_slots
);
  localparam int SW  = ADDR_W - SLOT_LOG2;
  localparam int P_I = 0;
  localparam int P_D = 1;
  localparam int P_B = 2;

  // named internal events
  logic cfg_load;
  assign cfg_load = !(i_en || d_en || b_en);

  logic [1:0]               ni_q, nd_q;
  logic [NBANK-1:0][BW-1:0] slot_bank;

  tcmalloc_cfg cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .itcm_code (itcm_sz),
    .dtcm_code (dtcm_sz),
    .ni_q      (ni_q),
    .nd_q      (nd_q),
    .bus_mask  (bus_mask),
    .bus_slots (bus_slots),
    .slot_bank (slot_bank)
  );

  // per-port decode
  logic          i_hit, d_hit, b_hit;
  logic [BW-1:0] i_bank, d_bank, b_bank;
  logic [ADDR_W-1:0] b_off;
  logic [SW-1:0]     b_slotw;

  assign i_hit  = {1'b0, i_addr[SLOT_LOG2]} < ni_q;
  assign d_hit  = {1'b0, d_addr[SLOT_LOG2]} < nd_q;
  assign i_bank = tcm_bank(ITCM_TOP, int'(ni_q), int'(i_addr[SLOT_LOG2]));
  assign d_bank = tcm_bank(DTCM_TOP, int'(nd_q), int'(d_addr[SLOT_LOG2]));

  assign b_off   = b_addr - BUS_BASE[ADDR_W-1:0];
  assign b_slotw = b_off[ADDR_W-1:SLOT_LOG2];
  assign b_hit   = (b_addr >= BUS_BASE[ADDR_W-1:0]) && (b_slotw < SW'(bus_slots));

  always_comb begin
    b_bank = '0;
    for (int s = 0; s < NBANK; s++)
      if (b_slotw == SW'(s)) b_bank = slot_bank[s];
  end

  // gather ports into arrays
  logic [NPORT-1:0]                go, we;
  logic [NPORT-1:0][BW-1:0]        pbank;
  logic [NPORT-1:0][BANK_AW-1:0]   widx;
  logic [NPORT-1:0][DATA_W-1:0]    wdat;

  assign go[P_I]    = i_en && i_hit;
  assign go[P_D]    = d_en && d_hit;
  assign go[P_B]    = b_en && b_hit;
  assign we         = {b_we, d_we, i_we};
  assign pbank      = {b_bank, d_bank, i_bank};
  assign widx[P_I]  = i_addr[2 +: BANK_AW];
  assign widx[P_D]  = d_addr[2 +: BANK_AW];
  assign widx[P_B]  = b_addr[2 +: BANK_AW];
  assign wdat       = {b_wdata, d_wdata, i_wdata};

  logic [NBANK-1:0][DATA_W-1:0] bk_rdata;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic               bk_en, bk_we;
    logic [BANK_AW-1:0] bk_addr;
    logic [DATA_W-1:0]  bk_wd;

    always_comb begin
      bk_en   = 1'b0;
      bk_we   = 1'b0;
      bk_addr = '0;
      bk_wd   = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (go[p] && pbank[p] == BW'(g)) begin
          bk_en   = 1'b1;
          bk_we   = we[p];
          bk_addr = widx[p];
          bk_wd   = wdat[p];
        end
      end
    end

    tcmalloc_bank #(.AW(BANK_AW), .DW(DATA_W)) ram_i (
      .clk   (clk),
      .en    (bk_en),
      .we    (bk_we),
      .addr  (bk_addr),
      .wdata (bk_wd),
      .rdata (bk_rdata[g])
    );
  end

  tcmalloc_ret #(.DW(DATA_W), .BW(BW), .NB(NBANK)) ret_i_i (
    .clk(clk), .rst_n(rst_n), .en(i_en), .we(i_we), .hit(i_hit), .bank(i_bank),
    .bank_rdata(bk_rdata), .rdata(i_rdata), .err(i_err)
  );
  tcmalloc_ret #(.DW(DATA_W), .BW(BW), .NB(NBANK)) ret_d_i (
    .clk(clk), .rst_n(rst_n), .en(d_en), .we(d_we), .hit(d_hit), .bank(d_bank),
    .bank_rdata(bk_rdata), .rdata(d_rdata), .err(d_err)
  );
  tcmalloc_ret #(.DW(DATA_W), .BW(BW), .NB(NBANK)) ret_b_i (
    .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .hit(b_hit), .bank(b_bank),
    .bank_rdata(bk_rdata), .rdata(b_rdata), .err(b_err)
  );

  // address bits that alias inside a slot
  logic unused_addr_bits;
  assign unused_addr_bits = ^{i_addr[1:0], d_addr[1:0], b_addr[1:0],
                              i_addr[SLOT_LOG2-1:2+BANK_AW], d_addr[SLOT_LOG2-1:2+BANK_AW],
                              b_addr[SLOT_LOG2-1:2+BANK_AW], b_off[SLOT_LOG2-1:0]};
endmodule

// File: rtl/tcmalloc_chk.sv
module tcmalloc_chk #(
  parameter int DW = 32,
  parameter int NB = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          i_en,
  input logic          i_we,
  input logic          d_en,
  input logic          d_we,
  input logic          b_en,
  input logic          b_we,
  input logic [DW-1:0] i_rdata,
  input logic [DW-1:0] d_rdata,
  input logic [DW-1:0] b_rdata,
  input logic          i_err,
  input logic          d_err,
  input logic          b_err,
  input logic [NB-1:0] bus_mask,
  input logic [2:0]    bus_slots
);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(bus_mask));

  // R4
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_mask) == int'(bus_slots));

  // R6
  i_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_err |-> i_rdata == '0);

  // R6
  d_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_err |-> d_rdata == '0);

  // R6
  b_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> !b_err);

  // R5
  b_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_en && !b_we) |=> b_rdata == '0);

  // R5
  i_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_en && !i_we) |=> i_rdata == '0);
endmodule

bind tcmalloc_top tcmalloc_chk #(.DW(DATA_W)) chk_i (.*);

// File: tb/tcmalloc_tb.sv
module tcmalloc_top_tb_top;
  localparam logic [31:0] BASE = 32'h0030_0000;
  localparam logic [31:0] SLOT = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  itcm_sz = 2'd0, dtcm_sz = 2'd0;
  logic        i_en = 0, i_we = 0, d_en = 0, d_we = 0, b_en = 0, b_we = 0;
  logic [14:0] i_addr = '0, d_addr = '0;
  logic [31:0] b_addr = '0, i_wdata = '0, d_wdata = '0, b_wdata = '0;
  logic [31:0] i_rdata, d_rdata, b_rdata;
  logic        i_err, d_err, b_err;
  logic [4:0]  bus_mask;
  logic [2:0]  bus_slots;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcmalloc_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic set_cfg(input logic [1:0] is, input logic [1:0] ds);
    @(negedge clk);
    itcm_sz = is;
    dtcm_sz = ds;
    @(negedge clk);
  endtask

  // p: 0 instruction, 1 data, 2 bus
  task automatic op(input int p, input logic w, input logic [31:0] a, input logic [31:0] wd,
                    output logic [31:0] rd, output logic er);
    @(negedge clk);
    case (p)
      0: begin i_en = 1; i_we = w; i_addr = a[14:0]; i_wdata = wd; end
      1: begin d_en = 1; d_we = w; d_addr = a[14:0]; d_wdata = wd; end
      default: begin b_en = 1; b_we = w; b_addr = a; b_wdata = wd; end
    endcase
    @(negedge clk);
    i_en = 0; d_en = 0; b_en = 0;
    case (p)
      0: begin rd = i_rdata; er = i_err; end
      1: begin rd = d_rdata; er = d_err; end
      default: begin rd = b_rdata; er = b_err; end
    endcase
  endtask

  // {itcm code, dtcm code, expected mask, expected slots}
  localparam logic [11:0] CFG_VEC [12] = '{
    {2'd0, 2'd0, 5'b11111, 3'd5},
    {2'd2, 2'd2, 5'b10000, 3'd1},
    {2'd1, 2'd2, 5'b10001, 3'd2},
    {2'd2, 2'd1, 5'b10100, 3'd2},
    {2'd1, 2'd1, 5'b10101, 3'd3},
    {2'd3, 2'd3, 5'b11111, 3'd5},
    {2'd0, 2'd2, 5'b10011, 3'd3},
    {2'd2, 2'd0, 5'b11100, 3'd3},
    {2'd1, 2'd0, 5'b11101, 3'd4},
    {2'd0, 2'd1, 5'b10111, 3'd4},
    {2'd3, 2'd1, 5'b10111, 3'd4},
    {2'd2, 2'd3, 5'b11100, 3'd3}
  };

  initial begin
    #2_000_000;
    nchk++;
    nfail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        er;

    // R1 reset state, with a non-default size presented
    itcm_sz = 2'd2;
    dtcm_sz = 2'd2;
    repeat (3) @(negedge clk);
    chk("R1 mask", 32'(bus_mask), 32'h1f);
    chk("R1 slots", 32'(bus_slots), 32'd5);
    chk("R1 rdata", i_rdata | d_rdata | b_rdata, 32'h0);
    chk("R1 err", 32'({i_err, d_err, b_err}), 32'h0);
    itcm_sz = 2'd0;
    dtcm_sz = 2'd0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mask after reset", 32'(bus_mask), 32'h1f);

    // R2 R4 size table, plus first empty slot past the window
    for (int k = 0; k < 12; k++) begin
      set_cfg(CFG_VEC[k][11:10], CFG_VEC[k][9:8]);
      chk($sformatf("R2 R4 mask vec%0d", k), 32'(bus_mask), 32'(CFG_VEC[k][7:3]));
      chk($sformatf("R4 slots vec%0d", k), 32'(bus_slots), 32'(CFG_VEC[k][2:0]));
      op(2, 0, BASE + 32'(CFG_VEC[k][2:0]) * SLOT, 0, rd, er);
      chk($sformatf("R6 past window vec%0d", k), {rd[30:0], er}, 32'h1);
    end

    // R4 fill all banks through the bus: slot s = bank 4-s
    set_cfg(0, 0);
    for (int s = 0; s < 5; s++) op(2, 1, BASE + 32'(s) * SLOT + 32'hC, 32'hA000 + 32'(s), rd, er);
    op(2, 1, BASE + 32'h10, 32'h0, rd, er);
    chk("R5 rdata after write", rd, 32'h0);

    // R3 R10 full tightly-coupled allocation
    set_cfg(2, 2);
    op(0, 0, 32'h000C, 0, rd, er); chk("R3 R10 itcm off0 is RB0", rd, 32'hA004);
    op(0, 0, 32'h400C, 0, rd, er); chk("R3 itcm off4000 is RB1", rd, 32'hA003);
    op(1, 0, 32'h000C, 0, rd, er); chk("R3 dtcm off0 is RB2", rd, 32'hA002);
    op(1, 0, 32'h400C, 0, rd, er); chk("R3 dtcm off4000 is RB3", rd, 32'hA001);
    op(2, 0, BASE + 32'hC, 0, rd, er); chk("R4 bus slot0 is RB4", rd, 32'hA000);

    // R3 R4 R6 half allocation
    set_cfg(1, 1);
    op(0, 0, 32'h000C, 0, rd, er); chk("R3 itcm16 is RB1", rd, 32'hA003);
    op(1, 0, 32'h000C, 0, rd, er); chk("R3 dtcm16 is RB3", rd, 32'hA001);
    op(2, 0, BASE + SLOT + 32'hC, 0, rd, er); chk("R4 bus slot1 is RB2", rd, 32'hA002);
    op(2, 0, BASE + 2 * SLOT + 32'hC, 0, rd, er); chk("R4 bus slot2 is RB0", rd, 32'hA004);
    op(0, 1, 32'h400C, 32'hDEAD, rd, er); chk("R6 itcm write past size err", {rd[30:0], er}, 32'h1);
    op(1, 0, 32'h400C, 0, rd, er); chk("R6 dtcm read past size err", {rd[30:0], er}, 32'h1);
    op(2, 1, BASE - 32'h4, 32'hBEEF, rd, er); chk("R6 bus below window err", {rd[30:0], er}, 32'h1);
    op(2, 0, BASE + 2 * SLOT + 32'hC, 0, rd, er); chk("R6 no error on hit", 32'(er), 32'h0);
    set_cfg(2, 2);
    op(0, 0, 32'h400C, 0, rd, er); chk("R6 rejected write left RB1", rd, 32'hA003);

    // R8 aliasing inside a slot
    set_cfg(0, 0);
    op(2, 1, BASE + 32'h1010, 32'h1234_5678, rd, er);
    op(2, 0, BASE + 32'h0010, 0, rd, er); chk("R8 alias word index", rd, 32'h1234_5678);

    // R9 three ports on three banks at once
    set_cfg(1, 1);
    @(negedge clk);
    i_en = 1; i_we = 1; i_addr = 15'h0020; i_wdata = 32'h1111;
    d_en = 1; d_we = 1; d_addr = 15'h0020; d_wdata = 32'h2222;
    b_en = 1; b_we = 1; b_addr = BASE + 32'h20; b_wdata = 32'h3333;
    @(negedge clk);
    i_we = 0; d_we = 0; b_we = 0;
    @(negedge clk);
    i_en = 0; d_en = 0; b_en = 0;
    chk("R9 itcm concurrent", i_rdata, 32'h1111);
    chk("R9 dtcm concurrent", d_rdata, 32'h2222);
    chk("R9 bus concurrent", b_rdata, 32'h3333);
    @(negedge clk);
    chk("R5 idle rdata zero", i_rdata | d_rdata | b_rdata, 32'h0);

    // R7 size change presented during a held bus read
    op(2, 1, BASE + 2 * SLOT + 32'h20, 32'h55, rd, er);
    @(negedge clk);
    b_en = 1; b_we = 0; b_addr = BASE + 2 * SLOT + 32'h20;
    itcm_sz = 2'd0; dtcm_sz = 2'd0;
    @(negedge clk);
    chk("R7 mask held while busy", 32'(bus_mask), 32'h15);
    chk("R7 read uses old map", b_rdata, 32'h55);
    @(negedge clk);
    chk("R7 mask still held", 32'(bus_mask), 32'h15);
    b_en = 0;
    @(negedge clk);
    chk("R7 mask after idle", 32'(bus_mask), 32'h1f);
    op(2, 0, BASE + 4 * SLOT + 32'h20, 0, rd, er);
    chk("R10 RB0 via new bus slot4", rd, 32'h55);

    finish_run();
  end
endmodule